// File: doc/BRIEF.md
# Line REI Byte Generator

This block builds the line remote error indication carried in the outgoing frame. Once per frame, at a boundary pulse, it captures the number of interleaved bit blocks that the receive-side line BIP-8 (B2) check found in error. It limits that number to the largest value the current mode allows and holds it for the frame that follows. In three-channel (STS-3/STM-1) mode the value fills the whole M1 byte. In single-channel (STS-1) mode it occupies the low nibble of M0, and the high nibble of M0 is passed through from the upstream byte.

A select input chooses whether the count comes from the local receive side or from a count supplied by a protection board. An inhibit input forces the indication to zero. A software error-insert strobe, when enabled, replaces the real count with exactly one error for one frame. The strobe is edge-detected, so holding it high still yields a single forced frame.

Top module: `line_rei_gen`

## Requirements
- R1: In three-channel mode (`mode_sts3`=1), after a frame pulse `m1_byte` equals the captured count as an unsigned binary value, and `m0_byte` equals `m0_in`.
- R2: In single-channel mode (`mode_sts3`=0), after a frame pulse `m0_byte[3:0]` holds the captured count, `m0_byte[7:4]` equals `m0_in[7:4]`, and `m1_byte` is 0.
- R3: The captured count is limited to 8 in single-channel mode and to 24 in three-channel mode; larger inputs are sent as that limit.
- R4: With `prot_sel`=1 the count is taken from `prot_err_cnt`; with `prot_sel`=0 it is taken from `local_err_cnt`.
- R5: If `inhibit`=1 at a frame pulse, the REI field sent for that frame is 0, and a pending forced error is discarded.
- R6: A rising edge of `force_strobe` while `force_en`=1 makes the next captured frame report exactly 1 error, whatever the real count. Later frames report the real count even if the strobe stays high.
- R7: A strobe edge seen while `force_en`=0 has no effect on the count that is sent.
- R8: The REI field changes only at a frame pulse. Between pulses it holds, even if the counts change.
- R9: After synchronous active-low reset the REI field is 0 and no forced error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_pulse | input | 1 | One-cycle frame boundary; the count is captured here |
| mode_sts3 | input | 1 | 1 = field in M1, 0 = field in M0 low nibble |
| local_err_cnt | input | CNT_W | Receive-side B2 block error count |
| prot_err_cnt | input | CNT_W | Block error count from the protection board |
| prot_sel | input | 1 | 1 selects the protection-board count |
| inhibit | input | 1 | Forces the REI field to zero |
| force_en | input | 1 | Enables software error insertion |
| force_strobe | input | 1 | Error-insert strobe; a rising edge arms one forced frame |
| m0_in | input | 8 | Upstream M0 byte; its high nibble is passed through |
| m1_byte | output | 8 | Outgoing M1 byte |
| m0_byte | output | 8 | Outgoing M0 byte |

## Verification
The REI field register is the only state behind the outputs. A wrong value in it appears on `m1_byte` or on the `m0_byte` low nibble right after the clock edge that samples a frame pulse, and it stays there for the whole frame. A stuck or lost forced-error flag gives no sign until the next frame pulse. It then shows as a count other than 1, or as a second frame reporting 1, so the bench checks the two frames that follow each strobe. A wrong limit or a wrong source choice shows only for counts above the mode's limit, or when the two inputs differ, and the vectors are chosen to cover those cases.

// File: rtl/rei_pkg.sv
// Shared definitions for the line REI generator.
// Assumes the REI field always fits in one overhead byte.
package rei_pkg;
    typedef logic [7:0] rei_byte_t;

    // Limit a count to a mode-dependent ceiling and return it as a byte.
    function automatic rei_byte_t rei_limit(input int unsigned cnt, input int unsigned lim);
        if (cnt > lim) return rei_byte_t'(lim);
        return rei_byte_t'(cnt);
    endfunction
endpackage

// File: rtl/rei_src_sel.sv
// Chooses the local or the protection-board error count and limits it to
// the ceiling of the active mode. Purely combinational.
// Assumes both counts are unsigned and CNT_W is at most 8.
module rei_src_sel
    import rei_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int MAX_STS1 = 8,
    parameter int MAX_STS3 = 24
) (
    input  logic [CNT_W-1:0] local_cnt,
    input  logic [CNT_W-1:0] prot_cnt,
    input  logic             prot_sel,
    input  logic             mode_sts3,
    output rei_byte_t        limited_cnt
);
    logic [CNT_W-1:0] picked;

    // Source mux, then mode-dependent ceiling.
    always_comb begin
        picked      = prot_sel ? prot_cnt : local_cnt;
        limited_cnt = rei_limit(int'(picked), mode_sts3 ? MAX_STS3 : MAX_STS1);
    end
endmodule

// File: rtl/rei_force_ctl.sv
// Detects a rising edge of the software error-insert strobe and keeps a
// pending flag until the next frame pulse consumes it.
// Assumes the strobe is synchronous to clk. An edge that arrives in the
// same cycle as a frame pulse is kept for the following frame.
module rei_force_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic force_en,
    input  logic force_strobe,
    input  logic frame_pulse,
    output logic pend
);
    logic strobe_d;
    logic arm;

    // Edge detector: an edge counts only while insertion is enabled.
    always_comb arm = force_en && force_strobe && !strobe_d;

    // Strobe history and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_d <= 1'b0;
            pend     <= 1'b0;
        end else begin
            strobe_d <= force_strobe;
            if (arm)              pend <= 1'b1;
            else if (frame_pulse) pend <= 1'b0;
        end
    end

    // R6: an armed request survives until a frame pulse takes it.
    a_r6_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !frame_pulse) |=> pend);

    // R7: with insertion disabled no new request can appear.
    a_r7_no_arm_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !force_en) |=> !pend);
endmodule

// File: rtl/rei_field_reg.sv
// Holds the REI field sent for the current frame. At each frame pulse it
// loads zero when inhibited, one when a forced error is pending, and the
// limited count otherwise.
// Assumes frame_pulse lasts one cycle.
module rei_field_reg
    import rei_pkg::*;
#(
    parameter int MAX_STS1 = 8,
    parameter int MAX_STS3 = 24
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_pulse,
    input  logic      inhibit,
    input  logic      pend,
    input  logic      mode_sts3,
    input  rei_byte_t cnt_in,
    output rei_byte_t field_q
);
    // Frame-boundary capture with inhibit taking priority over insertion.
    always_ff @(posedge clk) begin
        if (!rst_n)           field_q <= '0;
        else if (frame_pulse) begin
            if (inhibit)      field_q <= '0;
            else if (pend)    field_q <= 8'd1;
            else              field_q <= cnt_in;
        end
    end

    // R8: the field never moves between frame pulses.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(field_q));

    // R5: an inhibited frame carries zero.
    a_r5_inhibit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && inhibit) |=> (field_q == '0));

    // R6: a pending request yields exactly one error.
    a_r6_force_one: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && pend && !inhibit) |=> (field_q == 8'd1));

    // R3: the single-channel capture stays within its ceiling.
    a_r3_sts1_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !mode_sts3) |=> (int'(field_q) <= MAX_STS1));

    // R3: no capture exceeds the three-channel ceiling.
    a_r3_sts3_limit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (int'(field_q) <= MAX_STS3));
endmodule

// File: rtl/line_rei_gen.sv
// Line REI byte generator: captures the B2 block error count once per frame
// and places it in M1 (three-channel mode) or in the low nibble of M0
// (single-channel mode). It supports a protection-board source, an inhibit
// and a one-shot forced error.
// Assumes frame_pulse is one cycle wide and all inputs share clk.
module line_rei_gen
    import rei_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int MAX_STS1 = 8,
    parameter int MAX_STS3 = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             mode_sts3,
    input  logic [CNT_W-1:0] local_err_cnt,
    input  logic [CNT_W-1:0] prot_err_cnt,
    input  logic             prot_sel,
    input  logic             inhibit,
    input  logic             force_en,
    input  logic             force_strobe,
    input  logic [7:0]       m0_in,
    output logic [7:0]       m1_byte,
    output logic [7:0]       m0_byte
);
    rei_byte_t limited_cnt;
    rei_byte_t field_q;
    logic      pend;

    rei_src_sel #(.CNT_W(CNT_W), .MAX_STS1(MAX_STS1), .MAX_STS3(MAX_STS3)) u_src (
        .local_cnt   (local_err_cnt),
        .prot_cnt    (prot_err_cnt),
        .prot_sel    (prot_sel),
        .mode_sts3   (mode_sts3),
        .limited_cnt (limited_cnt)
    );

    rei_force_ctl u_force (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_en     (force_en),
        .force_strobe (force_strobe),
        .frame_pulse  (frame_pulse),
        .pend         (pend)
    );

    rei_field_reg #(.MAX_STS1(MAX_STS1), .MAX_STS3(MAX_STS3)) u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .inhibit     (inhibit),
        .pend        (pend),
        .mode_sts3   (mode_sts3),
        .cnt_in      (limited_cnt),
        .field_q     (field_q)
    );

    // Byte placement: full M1 byte, or M0 low nibble with upper nibble kept.
    always_comb begin
        if (mode_sts3) begin
            m1_byte = field_q;
            m0_byte = m0_in;
        end else begin
            m1_byte = '0;
            m0_byte = {m0_in[7:4], field_q[3:0]};
        end
    end
endmodule

// File: tb/line_rei_gen_tb.sv
module line_rei_gen_tb;
    localparam int NV = 11;
    // {mode, psel, inh, local[4:0], prot[4:0], m0_in, exp_m1, exp_m0}
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 5'd5,  5'd9,  8'hA5, 8'h05, 8'hA5}, // R1
        {1'b1, 1'b1, 1'b0, 5'd5,  5'd9,  8'hA5, 8'h09, 8'hA5}, // R4
        {1'b1, 1'b0, 1'b0, 5'd24, 5'd1,  8'h3C, 8'h18, 8'h3C}, // R3 edge
        {1'b1, 1'b0, 1'b0, 5'd30, 5'd1,  8'h3C, 8'h18, 8'h3C}, // R3 clamp
        {1'b0, 1'b0, 1'b0, 5'd3,  5'd7,  8'hA5, 8'h00, 8'hA3}, // R2
        {1'b0, 1'b0, 1'b0, 5'd8,  5'd0,  8'hF0, 8'h00, 8'hF8}, // R3 edge
        {1'b0, 1'b0, 1'b0, 5'd12, 5'd0,  8'h5F, 8'h00, 8'h58}, // R3 clamp
        {1'b0, 1'b1, 1'b0, 5'd0,  5'd31, 8'h00, 8'h00, 8'h08}, // R4 R3
        {1'b1, 1'b0, 1'b1, 5'd7,  5'd7,  8'h11, 8'h00, 8'h11}, // R5
        {1'b0, 1'b0, 1'b1, 5'd6,  5'd6,  8'hC9, 8'h00, 8'hC0}, // R5
        {1'b1, 1'b0, 1'b0, 5'd0,  5'd4,  8'h77, 8'h00, 8'h77}  // R1 zero
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       mode_sts3 = 1'b1;
    logic [4:0] local_err_cnt = '0;
    logic [4:0] prot_err_cnt = '0;
    logic       prot_sel = 1'b0;
    logic       inhibit = 1'b0;
    logic       force_en = 1'b0;
    logic       force_strobe = 1'b0;
    logic [7:0] m0_in = '0;
    logic [7:0] m1_byte;
    logic [7:0] m0_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    line_rei_gen u_dut (
        .clk (clk), .rst_n (rst_n), .frame_pulse (frame_pulse),
        .mode_sts3 (mode_sts3), .local_err_cnt (local_err_cnt),
        .prot_err_cnt (prot_err_cnt), .prot_sel (prot_sel),
        .inhibit (inhibit), .force_en (force_en), .force_strobe (force_strobe),
        .m0_in (m0_in), .m1_byte (m1_byte), .m0_byte (m0_byte)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Pulse one frame boundary, then return at the following falling edge.
    task automatic frame();
        @(negedge clk) frame_pulse = 1'b1;
        @(negedge clk) frame_pulse = 1'b0;
    endtask

    task automatic strobe_pulse();
        @(negedge clk) force_strobe = 1'b1;
        @(negedge clk) force_strobe = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset M1", m1_byte, 8'h00);
        mode_sts3 = 1'b0; m0_in = 8'h9E;
        #1 chk("R9 reset M0", m0_byte, 8'h90);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode_sts3     = VEC[i][36];
            prot_sel      = VEC[i][35];
            inhibit       = VEC[i][34];
            local_err_cnt = VEC[i][33:29];
            prot_err_cnt  = VEC[i][28:24];
            m0_in         = VEC[i][23:16];
            frame();
            chk($sformatf("vec%0d M1 (R1 R2 R3 R4 R5)", i), m1_byte, VEC[i][15:8]);
            chk($sformatf("vec%0d M0 (R1 R2 R3 R4 R5)", i), m0_byte, VEC[i][7:0]);
        end

        // R8: a count change without a pulse does not move the field
        mode_sts3 = 1'b1; prot_sel = 1'b0; inhibit = 1'b0;
        local_err_cnt = 5'd5; frame();
        local_err_cnt = 5'd12;
        repeat (3) @(negedge clk);
        chk("R8 hold", m1_byte, 8'h05);

        // R6: one strobe gives one forced frame
        local_err_cnt = 5'd7; force_en = 1'b1;
        strobe_pulse();
        chk("R6 before pulse", m1_byte, 8'h05);
        frame();
        chk("R6 forced frame", m1_byte, 8'h01);
        frame();
        chk("R6 next frame real", m1_byte, 8'h07);

        // R6: strobe held high across frames forces only once
        @(negedge clk) force_strobe = 1'b1;
        frame();
        chk("R6 held first", m1_byte, 8'h01);
        frame();
        chk("R6 held second", m1_byte, 8'h07);
        @(negedge clk) force_strobe = 1'b0;

        // R7: strobe while disabled is ignored
        force_en = 1'b0;
        strobe_pulse();
        frame();
        chk("R7 disabled strobe", m1_byte, 8'h07);

        // R6 in single-channel mode
        force_en = 1'b1; mode_sts3 = 1'b0; m0_in = 8'hB6;
        strobe_pulse();
        frame();
        chk("R6 sts1 forced", m0_byte, 8'hB1);

        // R5: inhibit beats and discards a pending force
        mode_sts3 = 1'b1;
        strobe_pulse();
        inhibit = 1'b1;
        frame();
        chk("R5 inhibit over force", m1_byte, 8'h00);
        inhibit = 1'b0;
        frame();
        chk("R5 force discarded", m1_byte, 8'h07);

        // R9: reset clears a pending force
        strobe_pulse();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R9 field cleared", m1_byte, 8'h00);
        frame();
        chk("R9 pending cleared", m1_byte, 8'h07);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule